// File: doc/BRIEF.md
# I2C Bit-Rate Clock Generator

This block turns a fast system clock into the half-period timing for an I2C master's SCL line. The divide is a product of two stages. The first stage is a power-of-two prescaler chosen by a 2-bit code. The second stage is a counter whose terminal count is an 8-bit rate value plus a fixed offset of 3, plus 2 more when the input-filter bit is set. The product of the two stages gives the number of system-clock cycles in each SCL half period. The block feeds a byte engine with three signals: a single-cycle tick at the start of every SCL phase, and two level flags that mark the low phase and the high phase.

Control comes from a 4-bit mode word and a 16-bit divider word. The mode word holds the enable, the prescaler select and the filter bit. Only the low byte of the divider word is used. A three-state machine sequences the phases:

- **IDLE**: the enable is low. Both flags are low, no ticks are produced and all counters are cleared.
- **LOW**: SCL is driven low.
- **HIGH**: SCL is released.

The machine has four transitions:

- **start**: IDLE to LOW, when the enable is seen high.
- **mid**: LOW to HIGH, when a half period ends.
- **wrap**: HIGH to LOW, when a half period ends.
- **stop**: any state to IDLE, when the enable is seen low.

The configuration is captured into a shadow copy only on start and on wrap. A register write made in the middle of a period therefore never shortens a phase.

Top module: `i2cbrg_top`

## Requirements
- R1: While mode bit 0 (enable) is low, including after reset, `tick`, `scl_low` and `scl_high` are all 0 from the next cycle on.
- R2: Mode bits 2:1 select the prescaler as 32 >> code, so codes 0, 1, 2 and 3 divide by 32, 16, 8 and 4.
- R3: Each SCL half period lasts P × (B + 3 + 2F) system cycles, where P is the prescaler, B is divider bits 7:0 (0 to 255) and F is the filter bit. This is the spacing between consecutive ticks.
- R4: Mode bit 3 (filter) adds exactly 2 to the second-stage term of every half period.
- R5: Divider bits 15:8 have no effect on the timing.
- R6: On the cycle after the enable is first seen high, `tick`=1 and `scl_low`=1. After that the phases alternate low and high, `tick` pulses for one cycle at each phase start, and `scl_low` and `scl_high` are never both 1.
- R7: A configuration change made during a period leaves both halves of that period at the old length. The new values apply from the next low-phase start.
- R8: Clearing the enable returns the block to IDLE on the next cycle. A later enable begins with a fresh, full-length low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_reg | input | 4 | Bit 0 enable, bits 2:1 prescaler code, bit 3 filter |
| div_reg | input | 16 | Divider word; bits 7:0 used |
| tick | output | 1 | One-cycle pulse at each SCL phase start |
| scl_low | output | 1 | SCL low phase in progress |
| scl_high | output | 1 | SCL high phase in progress |

## Verification
Each prescaler code is run with a rate value of 0. These runs separate the four prescaler factors from one another and test the offset of 3 on its own. Rate values of 0 and 255 are tried with the filter bit both clear and set. This exposes width truncation in the second stage and an offset of 2 added in the wrong place. A divider word with a non-zero upper byte shows that only the low byte counts. A configuration change made early in a low phase must give two old-length halves followed by two new-length halves, which separates deferred loading from immediate loading. Repeated enable and disable windows check the idle state and the restart in the low phase.

// File: rtl/i2cbrg_pkg.sv
package i2cbrg_pkg;
    localparam int SEL_W    = 2;
    localparam int BRG_W    = 8;
    localparam int PRE_LOG  = 5;
    localparam int EN_BIT   = 0;
    localparam int SEL_LSB  = 1;
    localparam int FILT_BIT = 3;
    localparam int MODE_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             filt;
        logic [BRG_W-1:0] brg;
    } brg_cfg_t;
endpackage

// File: rtl/i2cbrg_cfg_hold.sv
module i2cbrg_cfg_hold
    import i2cbrg_pkg::*;
#(
    parameter int DIV_REG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [MODE_W-1:0]    mode_reg,
    input  logic [DIV_REG_W-1:0] div_reg,
    output brg_cfg_t             cfg
);
    brg_cfg_t cfg_d;

    always_comb begin
        cfg_d.sel  = mode_reg[SEL_LSB +: SEL_W];
        cfg_d.filt = mode_reg[FILT_BIT];
        cfg_d.brg  = div_reg[BRG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (load) begin
            cfg <= cfg_d;
        end
    end
endmodule

// File: rtl/i2cbrg_prediv.sv
module i2cbrg_prediv
    import i2cbrg_pkg::*;
#(
    parameter int LOG_MAX = PRE_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             strobe
);
    localparam int CW = LOG_MAX;

    logic [CW:0]   limit_w;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt;

    always_comb begin
        limit_w = ({{CW{1'b0}}, 1'b1} << (LOG_MAX - int'(sel))) - 1'b1;
        limit   = limit_w[CW-1:0];
    end

    assign strobe = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || strobe) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cbrg_halfcnt.sv
module i2cbrg_halfcnt
    import i2cbrg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [BRG_W-1:0] brg,
    input  logic             filt,
    output logic             half_done
);
    localparam int TW = BRG_W + 1;

    logic [TW-1:0] last;
    logic [TW-1:0] cnt;

    always_comb begin
        last = {1'b0, brg} + TW'(2) + (filt ? TW'(2) : TW'(0));
    end

    assign half_done = run && step && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || half_done) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cbrg_top.sv
module i2cbrg_top
    import i2cbrg_pkg::*;
#(
    parameter int DIV_REG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           mode_reg,
    input  logic [DIV_REG_W-1:0] div_reg,
    output logic                 tick,
    output logic                 scl_low,
    output logic                 scl_high
);
    phase_e   state_q;
    phase_e   state_n;
    brg_cfg_t cfg;
    logic     en;
    logic     run;
    logic     pre_strobe;
    logic     half_done;
    logic     cfg_load;

    assign en       = mode_reg[EN_BIT];
    assign run      = en && (state_q != ST_IDLE);
    assign cfg_load = en && ((state_q == ST_IDLE) ||
                             (state_q == ST_HIGH && half_done));

    i2cbrg_cfg_hold #(.DIV_REG_W(DIV_REG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .mode_reg(mode_reg), .div_reg(div_reg), .cfg(cfg)
    );

    i2cbrg_prediv #(.LOG_MAX(PRE_LOG)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sel(cfg.sel), .strobe(pre_strobe)
    );

    i2cbrg_halfcnt u_half (
        .clk(clk), .rst_n(rst_n), .run(run), .step(pre_strobe),
        .brg(cfg.brg), .filt(cfg.filt), .half_done(half_done)
    );

    always_comb begin
        state_n = state_q;
        if (!en) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_n = ST_LOW;
                ST_LOW:  if (half_done) state_n = ST_HIGH;
                ST_HIGH: if (half_done) state_n = ST_LOW;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick     <= 1'b0;
            scl_low  <= 1'b0;
            scl_high <= 1'b0;
        end else begin
            tick     <= (state_n != state_q) && (state_n != ST_IDLE);
            scl_low  <= (state_n == ST_LOW);
            scl_high <= (state_n == ST_HIGH);
        end
    end
endmodule

// File: rtl/i2cbrg_chk.sv
module i2cbrg_chk
    import i2cbrg_pkg::*;
#(
    parameter int GAP_W = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mode_reg,
    input logic       tick,
    input logic       scl_low,
    input logic       scl_high
);
    localparam int MIN_GAP = (1 << (PRE_LOG - 3)) * 3;
    localparam int MAX_GAP = (1 << PRE_LOG) * ((1 << BRG_W) - 1 + 5);

    logic [GAP_W-1:0] gap;
    logic [GAP_W-1:0] prev_gap;
    logic [1:0]       nticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap      <= '0;
            prev_gap <= '0;
            nticks   <= '0;
        end else if (!scl_low && !scl_high && !tick) begin
            gap    <= '0;
            nticks <= '0;
        end else if (tick) begin
            prev_gap <= gap;
            gap      <= GAP_W'(1);
            if (nticks != 2'd3) nticks <= nticks + 1'b1;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_reg[EN_BIT] |=> (!tick && !scl_low && !scl_high));

    // R6
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_low, scl_high}));

    // R6
    rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_low) || $rose(scl_high)) |-> tick);

    // R6
    tick_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (scl_low || scl_high));

    // R7
    even_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && scl_low && nticks >= 2'd2) |-> (gap == prev_gap));

    // R3
    gap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && nticks >= 2'd1) |-> (gap >= GAP_W'(MIN_GAP) && gap <= GAP_W'(MAX_GAP)));
endmodule

bind i2cbrg_top i2cbrg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg),
    .tick(tick), .scl_low(scl_low), .scl_high(scl_high)
);

// File: tb/sim_i2cbrg_top.sv
module sim_i2cbrg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_reg = 4'h0;
    logic [15:0] div_reg = 16'h0;
    logic        tick, scl_low, scl_high;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int    gap;
        bit    hi;
        string req;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    i2cbrg_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .div_reg(div_reg),
        .tick(tick), .scl_low(scl_low), .scl_high(scl_high)
    );

    function automatic int half_len(int sel, int brg, int filt);
        return (32 >> sel) * (brg + 3 + 2 * filt);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int gap, bit hi, string req);
        exp_t e;
        e.gap = gap; e.hi = hi; e.req = req;
        q.push_back(e);
    endtask

    // monitor: measures tick spacing and compares with the scoreboard
    int cyc = 0;
    int last_t = 0;
    bit have_prev = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!scl_low && !scl_high && !tick) begin
                have_prev = 0;
            end else if (tick) begin
                if (have_prev) begin
                    if (q.size() == 0) begin
                        check(0, "R6", "unexpected tick", cyc - last_t, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(cyc - last_t == e.gap, e.req, "tick spacing", cyc - last_t, e.gap);
                        check(scl_high == e.hi, e.req, "phase level", int'(scl_high), int'(e.hi));
                    end
                end
                have_prev = 1;
                last_t = cyc;
            end
        end
    end

    task automatic quiet_window(int n, string req);
        bit ok = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick || scl_low || scl_high) ok = 0;
        end
        check(ok, req, "outputs quiet while disabled", int'({tick, scl_low, scl_high}), 0);
    endtask

    task automatic wait_drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_cfg(int sel, int brg, int filt, logic [7:0] upper, string req);
        int h;
        h = half_len(sel, brg, filt);
        push(h, 1, req); push(h, 0, req); push(h, 1, req); push(h, 0, req);
        div_reg = {upper, 8'(brg)};
        mode_reg = {1'(filt), 2'(sel), 1'b1};
        @(negedge clk);
        check(tick && scl_low && !scl_high, "R6", "first tick low phase",
              int'({tick, scl_low, scl_high}), 6);
        wait_drain();
        mode_reg[0] = 1'b0;
        @(negedge clk);
        check(!tick && !scl_low && !scl_high, "R8", "idle after disable",
              int'({tick, scl_low, scl_high}), 0);
        quiet_window(20, "R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!tick && !scl_low && !scl_high, "R1", "reset state",
              int'({tick, scl_low, scl_high}), 0);
        rst_n = 1'b1;
        quiet_window(20, "R1");

        // R2: all four prescaler codes, rate value 0
        run_cfg(0, 0, 0, 8'h00, "R2");
        run_cfg(1, 0, 0, 8'h00, "R2");
        run_cfg(2, 0, 0, 8'h00, "R2");
        run_cfg(3, 0, 0, 8'h00, "R2");
        // R3: rate value extremes
        run_cfg(3, 255, 0, 8'h00, "R3");
        run_cfg(0, 255, 1, 8'h00, "R3");
        // R4: filter adds 2
        run_cfg(3, 0, 1, 8'h00, "R4");
        run_cfg(1, 10, 1, 8'h00, "R4");
        // R5: upper divider byte ignored
        run_cfg(2, 5, 0, 8'hA5, "R5");
        run_cfg(3, 0, 0, 8'hFF, "R5");

        // R7: change during the low phase takes effect at next period
        push(half_len(3, 20, 0), 1, "R7");
        push(half_len(3, 20, 0), 0, "R7");
        push(half_len(2, 1, 1), 1, "R7");
        push(half_len(2, 1, 1), 0, "R7");
        div_reg = 16'd20;
        mode_reg = 4'b0111;
        @(negedge clk);
        check(tick && scl_low, "R6", "first tick low phase", int'({tick, scl_low}), 3);
        repeat (3) @(negedge clk);
        div_reg = 16'd1;
        mode_reg = 4'b1101;
        wait_drain();

        // R8: disable mid-phase, then restart with full low phase
        repeat (7) @(negedge clk);
        mode_reg[0] = 1'b0;
        @(negedge clk);
        check(!tick && !scl_low && !scl_high, "R8", "idle after mid-phase disable",
              int'({tick, scl_low, scl_high}), 0);
        quiet_window(10, "R1");
        run_cfg(3, 2, 0, 8'h00, "R8");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule